// File: doc/BRIEF.md
# Nine-Bit Load/Shift Register with Merged Clocks

This block is a nine-bit storage register that can either capture a full word from its parallel inputs or move its contents one place toward the top bit, taking a new bit from a serial input. Nine bits fit one data byte together with its parity bit. A single mode input chooses between the two operations. Whichever operation is chosen takes effect on the rising edge of the effective clock. All nine stages are visible at the parallel outputs, and the top stage is also brought out as a serial output so that several registers can be chained.

Two clock inputs are merged into one effective clock by a logical OR. A rising edge on either input, while the other input stays low, advances the register. A design that uses only one clock input ties the other one low. An active-high master clear sets every stage to zero at once without waiting for a clock edge. It holds the register at zero for as long as it stays high.

Top module: `ldsh9_reg`

## Requirements
- R1: While the master clear is high the parallel output reads 0x000, including right after power-up.
- R2: If the mode input is 0 at a rising edge of the effective clock, the parallel output takes the value of the parallel input in that same edge (bit i to bit i).
- R3: If the mode input is 1 at a rising edge of the effective clock, output bit 0 takes the serial input and output bit i takes the previous output bit i-1, for i from 1 to 8.
- R4: The effective clock is the OR of the two clock inputs. A rising edge on either input clocks the register by itself while the other input is held low. The two inputs are never high together at a rising edge.
- R5: A rising edge on the master clear sets the parallel output to zero before any further clock edge.
- R6: While the master clear stays high, clock edges are ignored in both modes and the output stays at zero.
- R7: The serial output always equals output bit 8. After nine consecutive shifts, the bits shifted in appear on it in the order they entered, the earliest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First clock input, rising-edge active |
| clk_b | input | 1 | Second clock input, rising-edge active |
| mrst | input | 1 | Active-high asynchronous master clear |
| shift_en | input | 1 | Mode: 0 = parallel load, 1 = shift toward bit 8 |
| ser_in | input | 1 | Serial data entering at bit 0 |
| par_in | input | 9 | Parallel load word |
| q_out | output | 9 | Register contents, bit 0 to bit 8 |
| ser_out | output | 1 | Serial output, equal to bit 8 |

## Verification
The assertions check on every clock edge that a load copies the parallel word and that a shift moves each bit up one stage with the serial bit entering at the bottom. They also check that the register reads zero at every edge while the clear is high, and that the two clock inputs are never high together when either one rises. Only the bench's scenarios can show a few other behaviours. The clear acts between clock edges without waiting for one. Each clock input drives the register on its own. The serial stream leaves bit 8 in the order it entered. The bench checks all of these, together with a mixed random sequence, against its queue-based model.

// File: rtl/ldsh_pkg.sv
package ldsh_pkg;

    localparam int REG_W = 9;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

    function automatic mode_e decode_mode(input logic sel);
        return sel ? MODE_SHIFT : MODE_LOAD;
    endfunction

endpackage

// File: rtl/ldsh_clk_merge.sv
module ldsh_clk_merge (
    input  logic clk_a,
    input  logic clk_b,
    input  logic mrst,
    output logic clk_eff
);

    assign clk_eff = clk_a | clk_b;

    // R4
    clk_a_excl_chk: assert property (@(posedge clk_a) disable iff (mrst) !clk_b)
        else $error("clk_b high at a rising edge of clk_a");

    // R4
    clk_b_excl_chk: assert property (@(posedge clk_b) disable iff (mrst) !clk_a)
        else $error("clk_a high at a rising edge of clk_b");

endmodule

// File: rtl/ldsh_next.sv
module ldsh_next #(
    parameter int W = ldsh_pkg::REG_W
) (
    input  ldsh_pkg::mode_e mode,
    input  logic [W-1:0]    cur,
    input  logic [W-1:0]    par,
    input  logic            ser,
    output logic [W-1:0]    nxt
);
    import ldsh_pkg::*;

    logic [W-1:0] below;

    generate
        for (genvar i = 0; i < W; i++) begin : g_stage
            if (i == 0) begin : g_entry
                assign below[i] = ser;
            end else begin : g_chain
                assign below[i] = cur[i-1];
            end
            assign nxt[i] = (mode == MODE_SHIFT) ? below[i] : par[i];
        end
    endgenerate

endmodule

// File: rtl/ldsh9_reg.sv
module ldsh9_reg #(
    parameter int W = ldsh_pkg::REG_W
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         mrst,
    input  logic         shift_en,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q_out,
    output logic         ser_out
);
    import ldsh_pkg::*;

    localparam int TOP = W - 1;

    logic         clk_eff;
    mode_e        mode;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    assign mode = decode_mode(shift_en);

    ldsh_clk_merge u_clk (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .mrst    (mrst),
        .clk_eff (clk_eff)
    );

    ldsh_next #(.W(W)) u_next (
        .mode (mode),
        .cur  (q_r),
        .par  (par_in),
        .ser  (ser_in),
        .nxt  (q_nxt)
    );

    always_ff @(posedge clk_eff or posedge mrst) begin
        if (mrst) q_r <= '0;
        else      q_r <= q_nxt;
    end

    assign q_out   = q_r;
    assign ser_out = q_r[TOP];

    // R2
    load_copy_chk: assert property (@(posedge clk_eff) disable iff (mrst)
        (mode == MODE_LOAD) |=> (q_out == $past(par_in)))
        else $error("parallel load did not copy the input word");

    // R3
    shift_move_chk: assert property (@(posedge clk_eff) disable iff (mrst)
        (mode == MODE_SHIFT) |=> (q_out == {$past(q_out[TOP-1:0]), $past(ser_in)}))
        else $error("shift did not move bits up by one stage");

    // R6
    clear_hold_chk: assert property (@(posedge clk_eff) mrst |-> (q_out == '0))
        else $error("register not zero while clear is high");

endmodule

// File: tb/ldsh9_reg_tb.sv
`timescale 1ns/1ps
module ldsh9_reg_tb;

    localparam int W = 9;

    logic         tick = 1'b0;
    logic         use_b = 1'b0;
    logic         mrst = 1'b1;
    logic         shift_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q_out;
    logic         ser_out;
    logic         clk_a;
    logic         clk_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit mdl[$];

    assign clk_a = tick & ~use_b;
    assign clk_b = tick & use_b;

    always #2 tick = ~tick;

    ldsh9_reg #(.W(W)) u_dut (
        .clk_a (clk_a), .clk_b (clk_b), .mrst (mrst), .shift_en (shift_en),
        .ser_in (ser_in), .par_in (par_in), .q_out (q_out), .ser_out (ser_out)
    );

    function automatic logic [W-1:0] mdl_word();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = mdl[i];
        return v;
    endfunction

    task automatic mdl_clear();
        mdl.delete();
        for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, advance model at posedge, compare at next negedge
    task automatic step(input logic m, input logic s, input logic [W-1:0] d, input string req);
        shift_en = m; ser_in = s; par_in = d;
        @(posedge tick);
        if (mrst) mdl_clear();
        else if (m) begin
            mdl.push_front(s);
            void'(mdl.pop_back());
        end else begin
            mdl.delete();
            for (int i = 0; i < W; i++) mdl.push_back(d[i]);
        end
        @(negedge tick);
        check(req, q_out, mdl_word());
        check({req, " ser_out"}, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, mdl[W-1]});
    endtask

    initial begin
        repeat (5000) @(posedge tick);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit stream[$];
        mdl_clear();
        // R1: reset state, clocks ignored while held
        step(1'b0, 1'b1, 9'h1FF, "R1");
        step(1'b1, 1'b1, 9'h0AA, "R1");
        mrst = 1'b0;

        // R2: parallel loads of several patterns
        step(1'b0, 1'b0, 9'h1A5, "R2");
        step(1'b0, 1'b1, 9'h05A, "R2");
        step(1'b0, 1'b0, 9'h1FF, "R2");
        step(1'b0, 1'b1, 9'h000, "R2");
        step(1'b0, 1'b0, 9'h100, "R2");

        // R3/R7: shift a stream in, then flush it out through ser_out
        for (int i = 0; i < W; i++) stream.push_back(((i * 5) % 3) == 1);
        for (int i = 0; i < 2 * W; i++) begin
            step(1'b1, (i < W) ? stream[i] : 1'b0, 9'h155, "R3");
            if (i >= W - 1)
                check("R7", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, stream[i-(W-1)]});
        end

        // R4: second clock input alone
        use_b = 1'b1;
        step(1'b0, 1'b0, 9'h0F3, "R4");
        step(1'b1, 1'b1, 9'h000, "R4");
        step(1'b1, 1'b0, 9'h000, "R4");
        use_b = 1'b0;
        step(1'b1, 1'b1, 9'h000, "R4");
        step(1'b0, 1'b0, 9'h12C, "R4");

        // R5: clear between edges in the middle of shifting
        step(1'b1, 1'b1, 9'h000, "R3");
        #0.5 mrst = 1'b1;
        #0.5 check("R5", q_out, 9'h000);
        mdl_clear();
        @(negedge tick);
        // R6: load and shift edges ignored while clear is high
        step(1'b0, 1'b1, 9'h1EF, "R6");
        step(1'b1, 1'b1, 9'h0FF, "R6");
        mrst = 1'b0;
        step(1'b1, 1'b1, 9'h000, "R3");

        // mixed random traffic on both clock inputs
        for (int i = 0; i < 60; i++) begin
            use_b = (i % 7) > 3;
            step($urandom_range(1, 0), $urandom_range(1, 0), 9'($urandom), "R2/R3 mix");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule